// File: doc/BRIEF.md
# Trivium keystream cipher core

This block is a synchronous stream cipher engine. Its 288-bit state is split into three shift registers of 93, 84 and 111 bits. Each register is fed from a neighbour through a term that mixes XOR taps with one AND of two adjacent taps. A pulse on `start` seeds the state from an 80-bit key and an 80-bit initial value. The engine then runs a fixed warm-up of 1152 state steps and throws that keystream away. After warm-up the engine advances only when a message beat is accepted.

Message bits arrive on a valid/ready input. Each accepted bit is XORed with the matching keystream bit, and the result appears one clock later on a registered output. The same operation serves for encryption and for decryption. The parameter `LANES` sets how many keystream bits are made per clock. With `LANES = 2` the next-state logic is unrolled two steps deep, so the state advances two positions per clock and the warm-up takes 576 clocks. The bit stream is the same in both modes.

Top module: `tvm_core`

## Requirements
- R1: After reset, `busy`, `in_ready` and `out_valid` are low and `out_data` is zero. `in_ready` stays low until a `start` pulse has been taken and warm-up has finished.
- R2: A `start` pulse loads the state as follows. `key[i]` goes to state bit s(i+1) for i = 0..79. `iv[i]` goes to s(94+i). s286, s287 and s288 are set to 1. Every other bit is 0.
- R3: One step computes a = s66^s93, b = s162^s177 and c = s243^s288, with keystream bit a^b^c. Register one takes c^(s286&s287)^s69 into s1 and shifts toward s93. Register two takes a^(s91&s92)^s171 into s94 and shifts toward s177. Register three takes b^(s175&s176)^s264 into s178 and shifts toward s288.
- R4: After a `start` pulse, `busy` is high for exactly 1152/LANES clocks, and `in_ready` is low for all of that time. After that, `busy` is low and `in_ready` is high. The keystream of those steps never reaches the output.
- R5: A beat is accepted on a clock where both `in_valid` and `in_ready` are high. In the next cycle `out_valid` is high and `out_data` equals `in_data` XOR the next LANES keystream bits.
- R6: The state advances only on accepted beats. Idle cycles between beats do not change the keystream that the following beats receive.
- R7: With LANES = 2, bit 0 of `in_data`/`out_data` carries the earlier keystream bit and bit 1 the later one. The bit stream is identical to the one-lane build.
- R8: A `start` pulse in any phase aborts the current work, reloads the state and restarts the full warm-up count. `in_ready` is low during the `start` cycle, so no beat is taken in that cycle.
- R9: Feeding the ciphertext back under the same key and initial value returns the original message.
- R10: `out_valid` is low in every cycle that follows a clock with no accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load key and initial value, begin warm-up |
| key | input | 80 | Secret key |
| iv | input | 80 | Initial value |
| busy | output | 1 | Warm-up in progress |
| in_valid | input | 1 | Message beat offered |
| in_ready | output | 1 | Engine can take a beat |
| in_data | input | LANES | Message bits, bit 0 earliest |
| out_valid | output | 1 | Result beat present |
| out_data | output | LANES | Message XOR keystream |

## Verification
A reference model built from the step equations runs inside the bench. Both lane widths are checked against it and against each other. A swapped tap or an XOR written in place of an AND would change the stream at once. A warm-up count that is off by one, or one that is not restarted by a second `start`, shows up as a wrong `busy` length and a shifted stream. Gapped traffic catches a state that advances on idle cycles. A start pulse during streaming, with `in_valid` held high, catches a beat taken while the state reloads. A wrong lane order shows up as pairwise-swapped output bits in the two-lane build.

// File: rtl/tvm_pkg.sv
package tvm_pkg;

    localparam int ST_W       = 288;
    localparam int KEY_W      = 80;
    localparam int IV_W       = 80;
    localparam int REG_A_LEN  = 93;
    localparam int REG_B_LEN  = 84;
    localparam int IV_LSB     = REG_A_LEN;
    localparam int ONES_W     = 3;
    localparam int ROTATIONS  = 4;
    localparam int WARM_STEPS = ROTATIONS * ST_W;

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_WARM,
        MODE_RUN
    } mode_e;

    typedef struct packed {
        logic            z;
        logic [ST_W-1:0] nxt;
    } step_t;

    // One state step. Vector bit i holds state bit s(i+1).
    function automatic step_t tvm_step(input logic [ST_W-1:0] s);
        step_t r;
        logic  ta, tb, tc, fa, fb, fc;
        ta    = s[65]  ^ s[92];
        tb    = s[161] ^ s[176];
        tc    = s[242] ^ s[287];
        r.z   = ta ^ tb ^ tc;
        fa    = ta ^ (s[90]  & s[91])  ^ s[170];
        fb    = tb ^ (s[174] & s[175]) ^ s[263];
        fc    = tc ^ (s[285] & s[286]) ^ s[68];
        r.nxt = {s[286:177], fb, s[175:93], fa, s[91:0], fc};
        return r;
    endfunction

    function automatic logic [ST_W-1:0] tvm_seed(input logic [KEY_W-1:0] k,
                                                  input logic [IV_W-1:0]  v);
        logic [ST_W-1:0] s;
        s = '0;
        s[KEY_W-1:0]               = k;
        s[IV_LSB+IV_W-1:IV_LSB]    = v;
        s[ST_W-1:ST_W-ONES_W]      = '1;
        return s;
    endfunction

endpackage

// File: rtl/tvm_ctrl.sv
module tvm_ctrl
    import tvm_pkg::*;
#(
    parameter int WARM_CLKS = 1152
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    output logic in_ready,
    output logic busy,
    output logic load,
    output logic adv
);

    localparam int CNT_W = (WARM_CLKS > 2) ? $clog2(WARM_CLKS) : 1;

    typedef struct packed {
        mode_e            mode;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (start) begin
            c_d.mode = MODE_WARM;
            c_d.cnt  = CNT_W'(WARM_CLKS - 1);
        end else if (c_q.mode == MODE_WARM) begin
            if (c_q.cnt == '0) c_d.mode = MODE_RUN;
            else               c_d.cnt  = c_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{mode: MODE_IDLE, cnt: '0};
        else        c_q <= c_d;
    end

    assign busy     = (c_q.mode == MODE_WARM);
    assign in_ready = (c_q.mode == MODE_RUN) && !start;
    assign load     = start;
    assign adv      = (busy && !start) || (in_valid && in_ready);

    // Checker counter for the warm-up window length.
    logic [CNT_W:0] chk_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     chk_q <= '0;
        else if (start) chk_q <= '0;
        else if (busy)  chk_q <= chk_q + 1'b1;
    end

    assert_start_warm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_busy_no_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);
    assert_warm_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> chk_q == (CNT_W+1)'(WARM_CLKS));

endmodule

// File: rtl/tvm_state.sv
module tvm_state
    import tvm_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [KEY_W-1:0] key,
    input  logic [IV_W-1:0]  iv,
    output logic [LANES-1:0] ks
);

    typedef struct packed {
        logic [ST_W-1:0] s;
    } st_t;

    st_t st_d, st_q;
    logic [ST_W-1:0] chain [0:LANES];

    assign chain[0] = st_q.s;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        step_t res;
        assign res          = tvm_step(chain[g]);
        assign ks[g]        = res.z;
        assign chain[g + 1] = res.nxt;
    end

    always_comb begin
        st_d = st_q;
        if (load)     st_d.s = tvm_seed(key, iv);
        else if (adv) st_d.s = chain[LANES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !adv |=> $stable(st_q.s));
    assert_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.s[KEY_W-1:0] == $past(key))
              && (st_q.s[IV_LSB+IV_W-1:IV_LSB] == $past(iv))
              && (st_q.s[ST_W-1:ST_W-ONES_W] == '1)
              && (st_q.s[ST_W-ONES_W-1:IV_LSB+IV_W] == '0)
              && (st_q.s[IV_LSB-1:KEY_W] == '0));

endmodule

// File: rtl/tvm_mix.sv
module tvm_mix #(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [LANES-1:0] din,
    input  logic [LANES-1:0] ks,
    output logic             out_valid,
    output logic [LANES-1:0] out_data
);

    typedef struct packed {
        logic             valid;
        logic [LANES-1:0] data;
    } mix_t;

    mix_t m_d, m_q;

    always_comb begin
        m_d       = m_q;
        m_d.valid = accept;
        if (accept) m_d.data = din ^ ks;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign out_valid = m_q.valid;
    assign out_data  = m_q.data;

endmodule

// File: rtl/tvm_core.sv
module tvm_core
    import tvm_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [KEY_W-1:0] key,
    input  logic [IV_W-1:0]  iv,
    output logic             busy,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [LANES-1:0] in_data,
    output logic             out_valid,
    output logic [LANES-1:0] out_data
);

    localparam int WARM_CLKS = WARM_STEPS / LANES;

    logic             load, adv;
    logic [LANES-1:0] ks;

    tvm_ctrl #(.WARM_CLKS(WARM_CLKS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .busy     (busy),
        .load     (load),
        .adv      (adv)
    );

    tvm_state #(.LANES(LANES)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (adv),
        .key   (key),
        .iv    (iv),
        .ks    (ks)
    );

    tvm_mix #(.LANES(LANES)) u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (in_valid && in_ready),
        .din       (in_data),
        .ks        (ks),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assert_out_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
    assert_idle_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);

endmodule

// File: tb/tvm_core_tb.sv
`timescale 1ns/1ps
module tvm_core_tb;

    localparam int CLK_NS = 20;
    localparam int NB     = 256;
    localparam int W1     = 1152;
    localparam int W2     = 576;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [79:0] key_i = '0;
    logic [79:0] iv_i = '0;
    logic        v1 = 1'b0, r1, b1, ov1;
    logic        d1 = 1'b0, od1;
    logic        v2 = 1'b0, r2, b2, ov2;
    logic [1:0]  d2 = '0, od2;

    int n_chk = 0;
    int n_err = 0;

    bit [1:288] rs;
    bit msg [0:NB-1];
    bit ks  [0:NB-1];
    bit got [0:NB-1];
    bit sav [0:NB-1];
    bit pln [0:NB-1];

    always #(CLK_NS/2) clk = ~clk;

    tvm_core #(.LANES(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key_i), .iv(iv_i),
        .busy(b1), .in_valid(v1), .in_ready(r1), .in_data(d1),
        .out_valid(ov1), .out_data(od1));

    tvm_core #(.LANES(2)) u_dut_x2 (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key_i), .iv(iv_i),
        .busy(b2), .in_valid(v2), .in_ready(r2), .in_data(d2),
        .out_valid(ov2), .out_data(od2));

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    // Reference model, indexed s1..s288 as in the requirements (R2, R3).
    task automatic ref_load(input logic [79:0] k, input logic [79:0] v);
        rs = '0;
        for (int i = 0; i < 80; i++) begin
            rs[i + 1]  = k[i];
            rs[94 + i] = v[i];
        end
        rs[286] = 1'b1; rs[287] = 1'b1; rs[288] = 1'b1;
    endtask

    task automatic ref_step(output bit z);
        bit a, b, c, fa, fb, fc;
        a  = rs[66] ^ rs[93];
        b  = rs[162] ^ rs[177];
        c  = rs[243] ^ rs[288];
        z  = a ^ b ^ c;
        fa = a ^ (rs[91] & rs[92]) ^ rs[171];
        fb = b ^ (rs[175] & rs[176]) ^ rs[264];
        fc = c ^ (rs[286] & rs[287]) ^ rs[69];
        for (int i = 288; i > 178; i--) rs[i] = rs[i - 1];
        rs[178] = fb;
        for (int i = 177; i > 94; i--) rs[i] = rs[i - 1];
        rs[94] = fa;
        for (int i = 93; i > 1; i--) rs[i] = rs[i - 1];
        rs[1] = fc;
    endtask

    task automatic ref_gen(input logic [79:0] k, input logic [79:0] v);
        bit z;
        ref_load(k, v);
        repeat (W1) ref_step(z);
        for (int i = 0; i < NB; i++) begin
            ref_step(z);
            ks[i] = z;
        end
    endtask

    task automatic pulse_start(input logic [79:0] k, input logic [79:0] v);
        @(negedge clk);
        key_i = k; iv_i = v; start = 1'b1; v1 = 1'b0; v2 = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    // R4: busy length per lane width, no ready while busy.
    task automatic measure_warm(input string req);
        int c1 = 0, c2 = 0, ov = 0;
        for (int i = 0; i < 1300; i++) begin
            if (b1) c1++;
            if (b2) c2++;
            if ((b1 && r1) || (b2 && r2)) ov++;
            @(negedge clk);
        end
        check(c1 == W1, {req, " busy clocks one lane"}, c1, W1);
        check(c2 == W2, {req, " busy clocks two lanes"}, c2, W2);
        check(ov == 0, {req, " ready during busy"}, ov, 0);
        check(r1 && r2 && !b1 && !b2, {req, " ready after warm-up"},
              {r1, r2, b1, b2}, 4'b1100);
    endtask

    // Streams n bits; gap>0 inserts an idle cycle every gap beats (R6, R10).
    task automatic run_lane(input int lanes, input int n, input int gap,
                            input string req);
        int  k = 0, pk = 0, beat = 0;
        bit  pend;
        while (!(lanes == 1 ? r1 : r2)) @(negedge clk);
        forever begin
            pend = 1'b0;
            if (k < n && !(gap > 0 && (beat % gap) == gap - 1)) begin
                if (lanes == 1) begin v1 = 1'b1; d1 = msg[k]; end
                else begin v2 = 1'b1; d2 = {msg[k + 1], msg[k]}; end
                pend = 1'b1; pk = k; k += lanes;
            end else begin
                v1 = 1'b0; v2 = 1'b0;
            end
            beat++;
            @(negedge clk);
            if (pend) begin
                if (lanes == 1) begin
                    check(ov1 && od1 == (msg[pk] ^ ks[pk]), {req, " R5 lane1 beat"},
                          {ov1, od1}, {1'b1, msg[pk] ^ ks[pk]});
                    got[pk] = od1;
                end else begin
                    check(ov2 && od2 == {msg[pk+1] ^ ks[pk+1], msg[pk] ^ ks[pk]},
                          {req, " R7 lane2 beat"}, {ov2, od2},
                          {1'b1, msg[pk+1] ^ ks[pk+1], msg[pk] ^ ks[pk]});
                    got[pk] = od2[0]; got[pk + 1] = od2[1];
                end
            end else begin
                check(!(lanes == 1 ? ov1 : ov2), {req, " R10 idle beat"},
                      lanes == 1 ? ov1 : ov2, 0);
            end
            if (k >= n && !pend) begin
                v1 = 1'b0; v2 = 1'b0;
                break;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!b1 && !r1 && !ov1 && od1 == 0, "R1 reset one lane",
              {b1, r1, ov1, od1}, 0);
        check(!b2 && !r2 && !ov2 && od2 == 0, "R1 reset two lanes",
              {b2, r2, ov2, od2}, 0);
        v1 = 1'b1; v2 = 1'b1;
        repeat (3) @(negedge clk);
        check(!r1 && !ov1 && !ov2, "R1 no accept before start",
              {r1, ov1, ov2}, 0);
        v1 = 1'b0; v2 = 1'b0;
    endtask

    task automatic t_keystream(input logic [79:0] k, input logic [79:0] v,
                               input string req);
        int diff = 0;
        ref_gen(k, v);
        for (int i = 0; i < NB; i++) msg[i] = 1'b0;
        pulse_start(k, v);
        measure_warm({req, " R4"});
        run_lane(1, 200, 0, {req, " R3"});
        for (int i = 0; i < 200; i++) sav[i] = got[i];
        run_lane(2, 200, 0, {req, " R7"});
        for (int i = 0; i < 200; i++) if (sav[i] != got[i]) diff++;
        check(diff == 0, {req, " R7 lane streams identical"}, diff, 0);
    endtask

    task automatic t_gaps_decrypt();
        int diff = 0;
        ref_gen(80'h0123_4567_89AB_CDEF_F00D, 80'hA5A5_5A5A_3C3C_C3C3_9966);
        for (int i = 0; i < NB; i++) begin
            msg[i] = 1'((i * 7 + (i >> 3)) % 3 == 1);
            pln[i] = msg[i];
        end
        pulse_start(80'h0123_4567_89AB_CDEF_F00D, 80'hA5A5_5A5A_3C3C_C3C3_9966);
        measure_warm("R6 gaps");
        run_lane(1, 240, 3, "R6 gaps");
        run_lane(2, 240, 4, "R6 gaps");
        for (int i = 0; i < 240; i++) msg[i] = got[i];
        pulse_start(80'h0123_4567_89AB_CDEF_F00D, 80'hA5A5_5A5A_3C3C_C3C3_9966);
        run_lane(1, 240, 5, "R9 decrypt");
        for (int i = 0; i < 240; i++) if (got[i] != pln[i]) diff++;
        check(diff == 0, "R9 plaintext recovered", diff, 0);
    endtask

    task automatic t_abort();
        ref_gen(80'hFFFF_0000_FFFF_0000_1234, 80'h0000_FFFF_1111_2222_3333);
        for (int i = 0; i < NB; i++) msg[i] = 1'(i % 5 == 2);
        pulse_start(80'hDEAD_BEEF_0000_1111_2222, 80'h1);
        repeat (300) @(negedge clk);
        pulse_start(80'hFFFF_0000_FFFF_0000_1234, 80'h0000_FFFF_1111_2222_3333);
        measure_warm("R8 abort in warm-up");
        run_lane(1, 64, 0, "R8 after abort");
        // Start while streaming with a beat offered in the same cycle.
        @(negedge clk);
        start = 1'b1; v1 = 1'b1; d1 = 1'b1;
        #1;
        check(!r1, "R8 ready low in start cycle", r1, 0);
        @(negedge clk);
        start = 1'b0; v1 = 1'b0;
        check(!ov1 && b1, "R8 reload in run", {ov1, b1}, 2'b01);
        run_lane(1, 128, 0, "R8 restart from bit zero");
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_keystream('0, '0, "all-zero key R2");
        t_keystream('1, '1, "all-one key R2");
        t_keystream(80'h8000_0000_0000_0000_0001, 80'h0000_0000_0000_0000_8001,
                    "edge bits R2");
        t_gaps_decrypt();
        t_abort();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule